// File: doc/BRIEF.md
# Correctable-Error Address Suppression Cache

This block sits next to the read port of an ECC-protected memory and filters the correctable-error reports coming from the decoder. A cell that is stuck would otherwise raise a correctable-error event on every read of its word. The block avoids that with a one-entry address store. The first correctable error at a location raises an event and records that address. Later correctable errors at the same address are swallowed. A correctable error at any other address raises an event and replaces the stored address. Uncorrectable errors are never filtered and have their own event output.

Software can drop the stored entry with a one-cycle clear pulse, so the next correctable error at that location is reported again. The stored address and its valid flag are visible on output ports at all times. Both event outputs are single-cycle pulses, registered one clock after the qualifying read strobe.

Top module: `ceflt_cache`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it is released, `ent_valid`, `evt_single` and `evt_double` are 0.
- R2: A read with `rd_valid`=1, `err_single`=1 and `err_double`=0 while no entry is held raises `evt_single` for one cycle after the next clock edge. After that same edge, `ent_valid`=1 and `ent_addr` equals the read address.
- R3: A correctable error at an address equal to the held valid entry produces no `evt_single`, and the entry stays as it was.
- R4: A correctable error at an address different from a held valid entry raises `evt_single` and replaces `ent_addr` with the new address.
- R5: A read with `rd_valid`=1 and `err_double`=1 always raises `evt_double` one clock later, whether or not its address matches the entry. It never raises `evt_single` and never changes the entry, even when `err_single` is also 1.
- R6: `sw_clear`=1 makes `ent_valid` 0 after the next edge. If a capture falls in the same cycle, the clear wins: the event is still raised but nothing is stored.
- R7: Events are single-cycle pulses. An error flag presented with `rd_valid`=0 raises no event and leaves the entry unchanged.
- R8: `ent_addr` and `ent_valid` are readable continuously. After a clear, a correctable error at the previously held address is reported again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read-data strobe qualifying the error flags |
| rd_addr | input | AW | Address of the read word |
| err_single | input | 1 | Correctable error flag from the ECC decoder |
| err_double | input | 1 | Uncorrectable error flag from the ECC decoder |
| sw_clear | input | 1 | One-cycle pulse that invalidates the entry |
| evt_single | output | 1 | Filtered correctable-error event pulse |
| evt_double | output | 1 | Uncorrectable-error event pulse |
| ent_addr | output | AW | Address held in the entry |
| ent_valid | output | 1 | Entry holds a valid address |

## Verification
The assertions assume that the error flags matter only in cycles where `rd_valid` is high. They also assume that `sw_clear` is a pulse sampled on the same edge as the read strobe, so a clear and a capture can coincide. The directed stimulus drives every input on the falling edge and holds it for exactly one rising edge. It then returns the strobe and flags to 0, so each event can be tied to a single read. The stimulus deliberately covers the coincident cases: both error flags together, and a clear in the same cycle as a capture.

// File: rtl/ceflt_pkg.sv
package ceflt_pkg;

    localparam int CEFLT_AW_DEFAULT = 16;

    // Classification of one read beat
    typedef enum logic [1:0] {
        RK_IDLE   = 2'd0,
        RK_CLEAN  = 2'd1,
        RK_SINGLE = 2'd2,
        RK_DOUBLE = 2'd3
    } read_kind_e;

    typedef struct packed {
        logic report_single;
        logic report_double;
    } evt_req_t;

    // Uncorrectable dominates correctable; nothing counts without a strobe.
    function automatic read_kind_e classify(input logic vld, input logic se, input logic de);
        if (!vld)     return RK_IDLE;
        else if (de)  return RK_DOUBLE;
        else if (se)  return RK_SINGLE;
        else          return RK_CLEAN;
    endfunction

endpackage

// File: rtl/ceflt_match.sv
module ceflt_match #(
    parameter int AW    = 16,
    parameter int SLICE = 4
) (
    input  logic [AW-1:0] probe_addr,
    input  logic [AW-1:0] held_addr,
    input  logic          held_valid,
    output logic          hit
);
    localparam int NSL = (AW + SLICE - 1) / SLICE;
    localparam int PW  = NSL * SLICE;

    logic [PW-1:0]  pa;
    logic [PW-1:0]  ha;
    logic [NSL-1:0] eq;

    always_comb begin
        pa = '0;
        ha = '0;
        pa[AW-1:0] = probe_addr;
        ha[AW-1:0] = held_addr;
    end

    // Slice-wise compare keeps the reduction tree shallow
    for (genvar s = 0; s < NSL; s++) begin : g_slice
        assign eq[s] = (pa[s*SLICE +: SLICE] == ha[s*SLICE +: SLICE]);
    end

    assign hit = held_valid && (&eq);
endmodule

// File: rtl/ceflt_entry.sv
module ceflt_entry #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          cap,
    input  logic [AW-1:0] cap_addr,
    output logic          vld,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            addr <= '0;
        end else if (clr) begin
            vld  <= 1'b0;
        end else if (cap) begin
            vld  <= 1'b1;
            addr <= cap_addr;
        end
    end
endmodule

// File: rtl/ceflt_event.sv
module ceflt_event
    import ceflt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_req_t req,
    output logic     evt_single,
    output logic     evt_double
);
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_single <= 1'b0;
            evt_double <= 1'b0;
        end else begin
            evt_single <= req.report_single;
            evt_double <= req.report_double;
        end
    end
endmodule

// File: rtl/ceflt_cache.sv
module ceflt_cache
    import ceflt_pkg::*;
#(
    parameter int AW = CEFLT_AW_DEFAULT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_addr,
    input  logic          err_single,
    input  logic          err_double,
    input  logic          sw_clear,
    output logic          evt_single,
    output logic          evt_double,
    output logic [AW-1:0] ent_addr,
    output logic          ent_valid
);
    read_kind_e kind;
    logic       hit;
    logic       capture;
    evt_req_t   req;

    assign kind = classify(rd_valid, err_single, err_double);

    ceflt_match #(.AW(AW)) u_match (
        .probe_addr (rd_addr),
        .held_addr  (ent_addr),
        .held_valid (ent_valid),
        .hit        (hit)
    );

    // New correctable location: report and remember it
    assign capture = (kind == RK_SINGLE) && !hit;

    always_comb begin
        req.report_single = capture;
        req.report_double = (kind == RK_DOUBLE);
    end

    ceflt_entry #(.AW(AW)) u_entry (
        .clk      (clk),
        .rst      (rst),
        .clr      (sw_clear),
        .cap      (capture),
        .cap_addr (rd_addr),
        .vld      (ent_valid),
        .addr     (ent_addr)
    );

    ceflt_event u_event (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .evt_single (evt_single),
        .evt_double (evt_double)
    );
endmodule

// File: rtl/ceflt_cache_chk.sv
module ceflt_cache_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_valid,
    input logic [AW-1:0] rd_addr,
    input logic          err_single,
    input logic          err_double,
    input logic          sw_clear,
    input logic          evt_single,
    input logic          evt_double,
    input logic [AW-1:0] ent_addr,
    input logic          ent_valid
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!ent_valid && !evt_single && !evt_double));

    assert_new_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && err_single && !err_double && !sw_clear &&
         !(ent_valid && rd_addr == ent_addr))
        |=> (evt_single && ent_valid && ent_addr == $past(rd_addr)));

    assert_repeat_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && err_single && !err_double && ent_valid && rd_addr == ent_addr)
        |=> !evt_single);

    assert_double_passes_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && err_double) |=> (evt_double && !evt_single));

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
        sw_clear |=> !ent_valid);

    assert_strobe_needed_R7: assert property (@(posedge clk) disable iff (rst)
        (evt_single || evt_double) |-> $past(rd_valid));

    assert_events_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_single, evt_double}));

    assert_entry_steady_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_valid && !sw_clear) |=> ($stable(ent_valid) && $stable(ent_addr)));
endmodule

bind ceflt_cache ceflt_cache_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_valid   (rd_valid),
    .rd_addr    (rd_addr),
    .err_single (err_single),
    .err_double (err_double),
    .sw_clear   (sw_clear),
    .evt_single (evt_single),
    .evt_double (evt_double),
    .ent_addr   (ent_addr),
    .ent_valid  (ent_valid)
);

// File: tb/tb_ceflt_cache.sv
`timescale 1ns/1ps
module tb_ceflt_cache;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          rd_valid;
    logic [AW-1:0] rd_addr;
    logic          err_single;
    logic          err_double;
    logic          sw_clear;
    logic          evt_single;
    logic          evt_double;
    logic [AW-1:0] ent_addr;
    logic          ent_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [AW-1:0] A = 16'h1234;
    localparam logic [AW-1:0] B = 16'h1235;
    localparam logic [AW-1:0] C = 16'hBEEF;

    always #5 clk = ~clk;

    ceflt_cache #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .err_single(err_single), .err_double(err_double), .sw_clear(sw_clear),
        .evt_single(evt_single), .evt_double(evt_double),
        .ent_addr(ent_addr), .ent_valid(ent_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one beat on the falling edge, sample 1 ns after the rising edge
    task automatic beat(input logic v, input logic [AW-1:0] a, input logic se,
                        input logic de, input logic clr);
        @(negedge clk);
        rd_valid = v; rd_addr = a; err_single = se; err_double = de; sw_clear = clr;
        @(posedge clk);
        #1;
        rd_valid = 0; err_single = 0; err_double = 0; sw_clear = 0;
    endtask

    task automatic t_reset;
        rst = 1; rd_valid = 0; rd_addr = '0; err_single = 0; err_double = 0; sw_clear = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid in reset", 32'(ent_valid), 0);
        check("R1 evt_single in reset", 32'(evt_single), 0);
        @(negedge clk); rst = 0;
        @(posedge clk); #1;
        check("R1 valid after release", 32'(ent_valid), 0);
        check("R1 evt_double after release", 32'(evt_double), 0);
    endtask

    task automatic t_repeat;
        beat(1, A, 1, 0, 0);
        check("R2 first event", 32'(evt_single), 1);
        check("R2 captured valid", 32'(ent_valid), 1);
        check("R2 captured addr", 32'(ent_addr), 32'(A));
        for (int i = 0; i < 3; i++) begin
            beat(1, A, 1, 0, 0);
            check("R3 repeat suppressed", 32'(evt_single), 0);
            check("R3 entry kept", 32'(ent_addr), 32'(A));
        end
        beat(0, A, 0, 0, 0);
        check("R7 pulse dropped", 32'(evt_single), 0);
    endtask

    task automatic t_alternate;
        logic [AW-1:0] seq [4];
        seq[0] = B; seq[1] = A; seq[2] = B; seq[3] = C;
        for (int i = 0; i < 4; i++) begin
            beat(1, seq[i], 1, 0, 0);
            check("R4 alternate event", 32'(evt_single), 1);
            check("R4 entry replaced", 32'(ent_addr), 32'(seq[i]));
        end
    endtask

    task automatic t_double;
        beat(1, C, 0, 1, 0);
        check("R5 double at entry addr", 32'(evt_double), 1);
        check("R5 no single event", 32'(evt_single), 0);
        beat(1, A, 1, 1, 0);
        check("R5 both flags double event", 32'(evt_double), 1);
        check("R5 both flags no single", 32'(evt_single), 0);
        check("R5 entry unchanged", 32'(ent_addr), 32'(C));
        beat(0, A, 0, 0, 0);
        check("R7 double pulse dropped", 32'(evt_double), 0);
    endtask

    task automatic t_nostrobe;
        beat(0, B, 1, 1, 0);
        check("R7 no strobe single", 32'(evt_single), 0);
        check("R7 no strobe double", 32'(evt_double), 0);
        check("R7 no strobe entry", 32'(ent_addr), 32'(C));
        check("R8 entry still valid", 32'(ent_valid), 1);
    endtask

    task automatic t_clear;
        beat(0, '0, 0, 0, 1);
        check("R6 clear drops valid", 32'(ent_valid), 0);
        beat(1, C, 1, 0, 0);
        check("R8 repeat after clear reported", 32'(evt_single), 1);
        check("R8 readback addr", 32'(ent_addr), 32'(C));
        beat(1, B, 1, 0, 1);
        check("R6 clear+capture event", 32'(evt_single), 1);
        check("R6 clear wins over capture", 32'(ent_valid), 0);
        beat(1, B, 1, 0, 0);
        check("R6 not held so reported", 32'(evt_single), 1);
    endtask

    initial begin
        t_reset();
        t_repeat();
        t_alternate();
        t_double();
        t_nostrobe();
        t_clear();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule